// File: doc/BRIEF.md
# Abort Exception Qualification Unit

This block decides when a memory fault becomes an abort exception in a small in-order pipeline model. A fault on an instruction fetch does not raise anything at fetch time. It becomes a tag that travels with the instruction through a parameterised chain of stages. The tag is only acted on if the instruction leaves the execute stage and actually executes. A branch flush that removes the instruction first discards the tag. A data fault reported at the execute stage is treated the same way: it is dropped if the instruction fails its condition or is interrupted. Both kinds of fault are precise. They produce an abort request that carries the address of the faulting instruction and a snapshot of the status word.

Write faults reported late from the memory side arrive as a one-cycle pulse. They are imprecise and are merged into one pending flag. That flag is only turned into an abort while the mask bit is clear. The mask bit is forced to 1 at reset, on every abort this block takes, and on IRQ or FIQ entry. Software can write it through a one-bit write port. An entry event in the same cycle as a software write wins over the write.

The controller has three states. RUN means no abort is being signalled. PREC means a precise abort is signalled in this cycle. IMPR means an imprecise abort is signalled in this cycle. The state is chosen again in every cycle. The transitions are:
- RUN/PREC/IMPR to PREC when a precise fault qualifies.
- RUN to IMPR when the flag is pending, the mask is clear and no precise fault qualifies.
- Any state to RUN otherwise.

Top module: `abort_qual`

## Requirements
- R1: After reset, mask_o is 1, pending_o is 0 and take_o is 0.
- R2: A fetch-fault-tagged instruction leaving the last stage (adv_i=1) with ex_cond_i=1 and ex_intr_i=0 gives take_o=1 and precise_o=1 in the next cycle, with link_o equal to its fetch address.
- R3: flush_i invalidates every instruction younger than the execute stage, including the fetch in the same cycle, and also the execute-stage entry when adv_i is 1 with it. A discarded tag never produces an abort.
- R4: A fault on the instruction leaving execute (fetch tag or ex_dfault_i) produces no abort when ex_cond_i=0 or ex_intr_i=1.
- R5: save_o is 1 exactly when take_o is 1. saved_status_o then holds status_i from the cycle in which the abort qualified.
- R6: imp_fault_i while mask_o=1 sets pending_o=1 and produces no abort.
- R7: Once mask_o is 0 with pending_o=1 and no precise fault qualifying, the next cycle shows take_o=1, precise_o=0 and link_o=0.
- R8: mask_o becomes 1 after any cycle that takes an abort or has irq_entry_i or fiq_entry_i, even if a write of 0 happens in that same cycle. Otherwise mask_we_i loads mask_wd_i.
- R9: When a precise fault and a ready imprecise abort meet in the same cycle, the precise abort is taken and pending_o stays 1.
- R10: Several imprecise pulses before a take merge into one pending flag and yield exactly one imprecise abort.
- R11: pending_o is 0 in the cycle where the imprecise abort is signalled, unless a new pulse arrived in the qualifying cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Pipeline advances; the execute-stage entry leaves |
| flush_i | input | 1 | Branch flush of younger instructions |
| fetch_v_i | input | 1 | A fetched instruction enters stage 0 |
| fetch_pc_i | input | AW | Address of the fetched instruction |
| fetch_pf_i | input | 1 | Fetch of this instruction faulted |
| ex_cond_i | input | 1 | Execute-stage instruction passes its condition |
| ex_intr_i | input | 1 | Execute-stage instruction is interrupted |
| ex_dfault_i | input | 1 | Precise data fault on the execute-stage access |
| imp_fault_i | input | 1 | Imprecise write fault pulse from memory |
| irq_entry_i | input | 1 | IRQ exception entry |
| fiq_entry_i | input | 1 | FIQ exception entry |
| mask_we_i | input | 1 | Software write of the mask bit |
| mask_wd_i | input | 1 | Mask value to write |
| status_i | input | SW | Current processor status word |
| take_o | output | 1 | Abort exception request |
| precise_o | output | 1 | 1 = precise, 0 = imprecise |
| link_o | output | AW | Faulting instruction address (0 for imprecise) |
| save_o | output | 1 | Status save strobe |
| saved_status_o | output | SW | Status snapshot for the abort |
| mask_o | output | 1 | Imprecise-abort mask bit |
| pending_o | output | 1 | Imprecise fault pending |

## Verification
The bench pushes a faulting fetch into a flush. A design that kept the tag would raise an abort for an instruction that never ran. It also drives a data fault with a failed condition and with an interrupt, where a wrong design would abort on a dead instruction. A precise fault is timed to meet a ready imprecise one. A wrong arbiter would take the imprecise one or clear the pending flag. Two pulses are merged before unmasking, and a software clear is made to collide with IRQ entry. Counting pulses would give a second abort, and letting the write win would leave imprecise aborts open while the handler's state is unsaved.

// File: rtl/abq_pkg.sv
package abq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PREC = 2'd1,
        ST_IMPR = 2'd2
    } abq_state_e;

    typedef enum logic {
        KIND_IMPR = 1'b0,
        KIND_PREC = 1'b1
    } abq_kind_e;
endpackage

// File: rtl/abq_tagpipe.sv
module abq_tagpipe #(
    parameter int DEPTH = 3,
    parameter int AW    = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    input  logic          flush_i,
    input  logic          fetch_v_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic          fetch_pf_i,
    output logic          ex_v_o,
    output logic [AW-1:0] ex_pc_o,
    output logic          ex_pf_o
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] v_q;
    logic [DEPTH-1:0] pf_q;
    logic [AW-1:0]    pc_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic          src_v;
        logic          src_pf;
        logic [AW-1:0] src_pc;
        logic          kill;

        if (i == 0) begin : g_head
            assign src_v  = fetch_v_i;
            assign src_pf = fetch_pf_i;
            assign src_pc = fetch_pc_i;
        end else begin : g_body
            assign src_v  = v_q[i-1];
            assign src_pf = pf_q[i-1];
            assign src_pc = pc_q[i-1];
        end

        // younger than the branch in execute: always killed on flush;
        // the execute slot itself is killed only when it is refilled
        if (i == LAST) begin : g_exec_kill
            assign kill = flush_i & adv_i;
        end else begin : g_young_kill
            assign kill = flush_i;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                v_q[i]  <= 1'b0;
                pf_q[i] <= 1'b0;
                pc_q[i] <= '0;
            end else begin
                if (adv_i) begin
                    v_q[i]  <= src_v;
                    pf_q[i] <= src_pf;
                    pc_q[i] <= src_pc;
                end
                if (kill) begin
                    v_q[i] <= 1'b0;
                end
            end
        end
    end

    assign ex_v_o  = v_q[LAST];
    assign ex_pf_o = pf_q[LAST];
    assign ex_pc_o = pc_q[LAST];
endmodule

// File: rtl/abq_qualify.sv
module abq_qualify (
    input  logic adv_i,
    input  logic ex_v_i,
    input  logic ex_pf_i,
    input  logic ex_cond_i,
    input  logic ex_intr_i,
    input  logic ex_dfault_i,
    output logic prec_o
);
    logic executes;
    logic faulted;

    always_comb begin
        executes = adv_i & ex_v_i & ex_cond_i & ~ex_intr_i;
        faulted  = ex_pf_i | ex_dfault_i;
        prec_o   = executes & faulted;
    end
endmodule

// File: rtl/abq_mask.sv
module abq_mask (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic abort_entry_i,
    input  logic irq_entry_i,
    input  logic fiq_entry_i,
    input  logic mask_we_i,
    input  logic mask_wd_i,
    input  logic imp_fault_i,
    input  logic imp_take_i,
    output logic mask_o,
    output logic pending_o
);
    logic mask_q, mask_d;
    logic pend_q, pend_d;

    always_comb begin
        mask_d = mask_q;
        if (abort_entry_i || irq_entry_i || fiq_entry_i) begin
            mask_d = 1'b1;
        end else if (mask_we_i) begin
            mask_d = mask_wd_i;
        end
        pend_d = imp_fault_i | (pend_q & ~imp_take_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            mask_q <= mask_d;
            pend_q <= pend_d;
        end
    end

    assign mask_o    = mask_q;
    assign pending_o = pend_q;
endmodule

// File: rtl/abq_fsm.sv
module abq_fsm
    import abq_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          prec_i,
    input  logic          pend_i,
    input  logic          mask_i,
    input  logic [AW-1:0] ex_pc_i,
    input  logic [SW-1:0] status_i,
    output logic          imp_go_o,
    output logic          entry_o,
    output logic          take_o,
    output logic          precise_o,
    output logic          save_o,
    output logic [AW-1:0] link_o,
    output logic [SW-1:0] saved_status_o
);
    abq_state_e    state_q, state_d;
    logic [AW-1:0] link_q;
    logic [SW-1:0] stat_q;

    assign imp_go_o = pend_i & ~mask_i & ~prec_i & (state_q == ST_RUN);

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (prec_i)        state_d = ST_PREC;
                else if (imp_go_o) state_d = ST_IMPR;
            end
            ST_PREC: begin
                if (prec_i) state_d = ST_PREC;
            end
            ST_IMPR: begin
                if (prec_i) state_d = ST_PREC;
            end
            default: state_d = ST_RUN;
        endcase
        entry_o = (state_d != ST_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            link_q  <= '0;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_PREC) begin
                link_q <= ex_pc_i;
                stat_q <= status_i;
            end else if (state_d == ST_IMPR) begin
                link_q <= '0;
                stat_q <= status_i;
            end
        end
    end

    always_comb begin
        take_o    = 1'b0;
        precise_o = KIND_IMPR;
        unique case (state_q)
            ST_RUN: begin
                take_o = 1'b0;
            end
            ST_PREC: begin
                take_o    = 1'b1;
                precise_o = KIND_PREC;
            end
            ST_IMPR: begin
                take_o    = 1'b1;
                precise_o = KIND_IMPR;
            end
            default: take_o = 1'b0;
        endcase
        save_o         = take_o;
        link_o         = link_q;
        saved_status_o = stat_q;
    end
endmodule

// File: rtl/abort_qual.sv
module abort_qual #(
    parameter int DEPTH = 3,
    parameter int AW    = 16,
    parameter int SW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    input  logic          flush_i,
    input  logic          fetch_v_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic          fetch_pf_i,
    input  logic          ex_cond_i,
    input  logic          ex_intr_i,
    input  logic          ex_dfault_i,
    input  logic          imp_fault_i,
    input  logic          irq_entry_i,
    input  logic          fiq_entry_i,
    input  logic          mask_we_i,
    input  logic          mask_wd_i,
    input  logic [SW-1:0] status_i,
    output logic          take_o,
    output logic          precise_o,
    output logic [AW-1:0] link_o,
    output logic          save_o,
    output logic [SW-1:0] saved_status_o,
    output logic          mask_o,
    output logic          pending_o
);
    logic          ex_v, ex_pf, prec, imp_go, entry;
    logic [AW-1:0] ex_pc;

    abq_tagpipe #(.DEPTH(DEPTH), .AW(AW)) u_pipe (
        .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .flush_i(flush_i),
        .fetch_v_i(fetch_v_i), .fetch_pc_i(fetch_pc_i), .fetch_pf_i(fetch_pf_i),
        .ex_v_o(ex_v), .ex_pc_o(ex_pc), .ex_pf_o(ex_pf)
    );

    abq_qualify u_qual (
        .adv_i(adv_i), .ex_v_i(ex_v), .ex_pf_i(ex_pf), .ex_cond_i(ex_cond_i),
        .ex_intr_i(ex_intr_i), .ex_dfault_i(ex_dfault_i), .prec_o(prec)
    );

    abq_mask u_mask (
        .clk_i(clk_i), .rst_ni(rst_ni), .abort_entry_i(entry),
        .irq_entry_i(irq_entry_i), .fiq_entry_i(fiq_entry_i),
        .mask_we_i(mask_we_i), .mask_wd_i(mask_wd_i),
        .imp_fault_i(imp_fault_i), .imp_take_i(imp_go),
        .mask_o(mask_o), .pending_o(pending_o)
    );

    abq_fsm #(.AW(AW), .SW(SW)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .prec_i(prec), .pend_i(pending_o),
        .mask_i(mask_o), .ex_pc_i(ex_pc), .status_i(status_i),
        .imp_go_o(imp_go), .entry_o(entry), .take_o(take_o),
        .precise_o(precise_o), .save_o(save_o), .link_o(link_o),
        .saved_status_o(saved_status_o)
    );
endmodule

// File: rtl/abq_chk.sv
module abq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic adv_i,
    input logic ex_cond_i,
    input logic ex_intr_i,
    input logic imp_fault_i,
    input logic take_o,
    input logic precise_o,
    input logic save_o,
    input logic mask_o,
    input logic pending_o
);
    // R8
    mask_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> mask_o);

    // R7
    impr_needs_unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && !precise_o) |-> !$past(mask_o));

    // R11
    pend_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && !precise_o) |-> (!pending_o || $past(imp_fault_i)));

    // R2
    prec_needs_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && precise_o) |-> $past(adv_i));

    // R4
    dead_insn_no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!ex_cond_i || ex_intr_i) |-> !(take_o && precise_o));

    // R6
    masked_no_impr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mask_o) |-> !(take_o && !precise_o));

    // R5
    save_with_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(take_o) |-> save_o);
endmodule

bind abort_qual abq_chk u_abq_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .ex_cond_i(ex_cond_i),
    .ex_intr_i(ex_intr_i), .imp_fault_i(imp_fault_i), .take_o(take_o),
    .precise_o(precise_o), .save_o(save_o), .mask_o(mask_o), .pending_o(pending_o)
);

// File: tb/sim_abort_qual.sv
`timescale 1ns/1ps
module sim_abort_qual;
    localparam int D  = 3;
    localparam int AW = 16;
    localparam int SW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, adv, flush, fv, fpf, cond, intr, dfault, imp, irq, fiq, we, wd;
    logic [AW-1:0] fpc;
    logic [SW-1:0] status;
    logic take, precise, save, mask, pend;
    logic [AW-1:0] link;
    logic [SW-1:0] sstat;

    abort_qual #(.DEPTH(D), .AW(AW), .SW(SW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .flush_i(flush),
        .fetch_v_i(fv), .fetch_pc_i(fpc), .fetch_pf_i(fpf),
        .ex_cond_i(cond), .ex_intr_i(intr), .ex_dfault_i(dfault),
        .imp_fault_i(imp), .irq_entry_i(irq), .fiq_entry_i(fiq),
        .mask_we_i(we), .mask_wd_i(wd), .status_i(status),
        .take_o(take), .precise_o(precise), .link_o(link), .save_o(save),
        .saved_status_o(sstat), .mask_o(mask), .pending_o(pend)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit m_v [D];
    bit m_pf [D];
    logic [AW-1:0] m_pc [D];
    bit m_mask, m_pend, m_take, m_prec;
    logic [AW-1:0] m_link;
    logic [SW-1:0] m_stat;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit qualifies();
        return adv && m_v[D-1] && cond && !intr && (m_pf[D-1] || dfault);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < D; i++) begin m_v[i] = 0; m_pf[i] = 0; m_pc[i] = '0; end
        m_mask = 1; m_pend = 0; m_take = 0; m_prec = 0; m_link = '0; m_stat = '0;
    endtask

    task automatic model_step();
        bit p, ig;
        p  = qualifies();
        ig = m_pend && !m_mask && !p && !m_take;
        m_take = p || ig;
        m_prec = p;
        if (p) begin m_link = m_pc[D-1]; m_stat = status; end
        else if (ig) begin m_link = '0; m_stat = status; end
        if (p || ig || irq || fiq) m_mask = 1;
        else if (we) m_mask = wd;
        m_pend = imp || (m_pend && !ig);
        if (adv) begin
            for (int i = D-1; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_pf[i] = m_pf[i-1]; m_pc[i] = m_pc[i-1];
            end
            m_v[0] = fv; m_pf[0] = fpf; m_pc[0] = fpc;
        end
        if (flush) begin
            for (int i = 0; i < D-1; i++) m_v[i] = 0;
            if (adv) m_v[D-1] = 0;
        end
    endtask

    task automatic compare();
        chk(take == m_take, "R2 take", take, m_take);
        if (m_take) chk(precise == m_prec, "R7 kind", precise, m_prec);
        if (m_take) chk(link == m_link, "R2 link", link, m_link);
        chk(save == m_take, "R5 save", save, m_take);
        if (m_take) chk(sstat == m_stat, "R5 status", sstat, m_stat);
        chk(mask == m_mask, "R8 mask", mask, m_mask);
        chk(pend == m_pend, "R6 pending", pend, m_pend);
    endtask

    task automatic idle_inputs();
        adv = 0; flush = 0; fv = 0; fpf = 0; fpc = '0; cond = 1; intr = 0;
        dfault = 0; imp = 0; irq = 0; fiq = 0; we = 0; wd = 0; status = '0;
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        model_reset();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic unmask();
        we = 1; wd = 0; step();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1 reset state
        chk(mask == 1, "R1 mask", mask, 1);
        chk(pend == 0, "R1 pending", pend, 0);
        chk(take == 0, "R1 take", take, 0);

        // R2 and R5: tagged fetch reaches execute
        fv = 1; fpf = 1; fpc = 16'h1234; adv = 1; step();
        adv = 1; step();
        adv = 1; step();
        adv = 1; status = 8'h5A; step();
        chk(take && precise, "R2 precise take", {take, precise}, 2'b11);
        chk(link == 16'h1234, "R2 link", link, 16'h1234);
        chk(save && sstat == 8'h5A, "R5 snapshot", sstat, 8'h5A);

        // R3: flush drops a tagged instruction
        do_reset();
        fv = 1; fpf = 1; fpc = 16'h0200; adv = 1; step();
        flush = 1; step();
        for (int k = 0; k < 4; k++) begin
            adv = 1; step();
            chk(!take, "R3 no abort after flush", take, 0);
        end

        // R4: data fault on a dead instruction
        do_reset();
        fv = 1; fpc = 16'h0300; adv = 1; step();
        adv = 1; step();
        adv = 1; step();
        adv = 1; dfault = 1; cond = 0; step();
        chk(!take, "R4 cond fail drops fault", take, 0);
        fv = 1; fpc = 16'h0304; adv = 1; step();
        adv = 1; step();
        adv = 1; step();
        adv = 1; dfault = 1; intr = 1; step();
        chk(!take, "R4 interrupt drops fault", take, 0);
        fv = 1; fpc = 16'h0308; adv = 1; step();
        adv = 1; step();
        adv = 1; step();
        adv = 1; dfault = 1; step();
        chk(take && precise && link == 16'h0308, "R4 live data fault", link, 16'h0308);

        // R6, R10, R7, R11, R8: masked imprecise faults
        do_reset();
        imp = 1; step();
        step();
        imp = 1; step();
        for (int k = 0; k < 3; k++) begin
            step();
            chk(pend && !take, "R6 held pending", {pend, take}, 2'b10);
        end
        unmask();
        chk(!mask && pend && !take, "R7 unmasked", {mask, pend, take}, 3'b010);
        step();
        chk(take && !precise && link == '0, "R7 imprecise take", {take, precise}, 2'b10);
        chk(!pend, "R11 pending cleared", pend, 0);
        chk(mask, "R8 mask set by abort", mask, 1);
        unmask();
        for (int k = 0; k < 3; k++) begin
            step();
            chk(!take, "R10 merged single abort", take, 0);
        end

        // R9: precise beats ready imprecise
        do_reset();
        unmask();
        fv = 1; fpf = 1; fpc = 16'h0440; adv = 1; step();
        adv = 1; step();
        adv = 1; imp = 1; step();
        adv = 1; step();
        chk(take && precise, "R9 precise wins", {take, precise}, 2'b11);
        chk(pend, "R9 imprecise kept", pend, 1);
        step();
        chk(!take && pend, "R9 still pending under mask", {take, pend}, 2'b01);

        // R8: entry events vs software write
        do_reset();
        unmask();
        irq = 1; step();
        chk(mask, "R8 irq sets mask", mask, 1);
        unmask();
        fiq = 1; step();
        chk(mask, "R8 fiq sets mask", mask, 1);
        irq = 1; we = 1; wd = 0; step();
        chk(mask, "R8 entry beats write", mask, 1);

        // random mix checked against the model
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            adv    = ($urandom % 10) < 7;
            flush  = ($urandom % 12) == 0;
            fv     = ($urandom % 4) != 0;
            fpf    = ($urandom % 5) == 0;
            fpc    = AW'($urandom);
            cond   = ($urandom % 5) != 0;
            intr   = ($urandom % 10) == 0;
            dfault = ($urandom % 7) == 0;
            imp    = ($urandom % 20) == 0;
            irq    = ($urandom % 50) == 0;
            fiq    = ($urandom % 50) == 0;
            we     = ($urandom % 8) == 0;
            wd     = ($urandom % 4) == 0;
            status = SW'($urandom);
            step();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule